// File: doc/BRIEF.md
# Software Write-Protect Command Controller

This block sits behind the byte-level front end of a small serial EEPROM and handles the commands that control write protection of the upper half of the array. Each command has three bytes: a command byte, a don't-care address byte and a don't-care data byte, followed by a STOP. The front end strobes each byte in with its phase and the decoded command kind. The controller then returns an acknowledge or no-acknowledge decision for that byte.

The controller keeps two protect flags. The reversible flag can be set and cleared. The permanent flag can only ever be set. A command is committed only if all three of its bytes were acknowledged before the STOP. A commit starts a fixed-length internal write period, and the flag changes when that period ends. The acknowledge decision depends on several things: whether the command would change a flag or only restate its current value, the level of the WP pin, the permanent flag, and whether a write is still in progress.

The permanent flag is non-volatile in silicon. Here it is loaded from a sideband level input whenever the block is in reset. A power-on hold input acts as a reset and also raises a whole-array write inhibit.

Top module: `swp_cmd_ctrl`

## Requirements
- R1: While `rst` or `por_hold` is high, and on the first cycle after it is released, the outputs are as follows: `rev_flag` is 0, `perm_flag` equals `perm_nv`, `busy` is 0 and `ack_vld` is 0. `wr_inhibit` is high exactly while `por_hold` is high.
- R2: Each byte is presented for one cycle with `phase_vld`=1. `phase` encodes the byte: 0 for command, 1 for address, 2 for data. `cmd` encodes the command: 0 for none, 1 for reversible set, 2 for reversible clear, 3 for permanent set. The cycle after a byte is presented, `ack_vld` is 1 and `ack` carries the decision (1 = acknowledge). In every other cycle `ack_vld` is 0.
- R3: With WP low, both flags clear, no write in progress and a command that would change a flag, all three bytes are acknowledged. A STOP then starts the write. The flag takes its new value exactly `WR_CYCLES` cycles after the cycle in which STOP was sampled. At no other time do the flags change.
- R4: With WP high and the permanent flag clear, a command that would change a flag has its command and address bytes acknowledged and its data byte rejected. The flags are then left unchanged.
- R5: A command that restates the current state of its flag is rejected at the command byte, and its later bytes are also rejected. This holds whether WP is high or low. A command code of 0 is treated the same way.
- R6: While the permanent flag is set, every command byte is rejected, together with its address and data bytes.
- R7: An accepted permanent-set command sets `perm_flag` when its write ends. No command can clear `perm_flag`.
- R8: `busy` is high from the cycle after a committing STOP until the flag update, a span of `WR_CYCLES` cycles. Any command byte presented while `busy` is high is rejected.
- R9: A STOP that comes before the data byte has been acknowledged does not start a write.
- R10: `upper_locked` is the OR of `rev_flag` and `perm_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| por_hold | input | 1 | Power-on hold; acts as reset and inhibits array writes |
| perm_nv | input | 1 | Stored permanent-flag value, loaded during reset |
| wp_pin | input | 1 | Write-protect pin level |
| phase_vld | input | 1 | One-cycle strobe for a received byte |
| phase | input | 2 | Byte phase: 0 command, 1 address, 2 data |
| cmd | input | 2 | Command kind: 0 none, 1 reversible set, 2 reversible clear, 3 permanent set |
| stop | input | 1 | One-cycle STOP strobe |
| ack_vld | output | 1 | Acknowledge decision valid |
| ack | output | 1 | 1 = acknowledge, 0 = reject |
| busy | output | 1 | Internal write in progress |
| rev_flag | output | 1 | Reversible protect flag |
| perm_flag | output | 1 | Permanent protect flag |
| upper_locked | output | 1 | Upper half of the array is write-protected |
| wr_inhibit | output | 1 | Whole array write-inhibited (power-on hold) |

## Verification
The acknowledge decision for a byte strobed at clock edge N is visible after edge N+1. The bench drives the strobe on a falling edge and reads `ack` on the following falling edge. After STOP is sampled at edge E, `busy` reads high from E+1 and the flag update takes effect at E+`WR_CYCLES`. The bench counts falling edges after the STOP and checks the flag one cycle before and at that edge. A behavioural model in the bench steps on every rising edge, and all outputs are compared with it at every falling edge.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_RSET = 2'd1,
        CMD_RCLR = 2'd2,
        CMD_PSET = 2'd3
    } swp_cmd_e;

    typedef enum logic [1:0] {
        PH_CMD  = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_RSVD = 2'd3
    } swp_phase_e;

    // Per-transaction plan fixed at the command byte
    typedef enum logic [1:0] {
        PLAN_IDLE   = 2'd0,
        PLAN_REJECT = 2'd1,
        PLAN_NODATA = 2'd2,
        PLAN_ALL    = 2'd3
    } swp_plan_e;

    typedef struct packed {
        logic rev;
        logic perm;
    } swp_flags_t;

    function automatic logic would_flip(swp_cmd_e c, swp_flags_t f);
        case (c)
            CMD_RSET: return !f.rev;
            CMD_RCLR: return f.rev;
            CMD_PSET: return !f.perm;
            default:  return 1'b0;
        endcase
    endfunction

    function automatic swp_flags_t apply_cmd(swp_cmd_e c, swp_flags_t f);
        swp_flags_t n;
        n = f;
        case (c)
            CMD_RSET: n.rev  = 1'b1;
            CMD_RCLR: n.rev  = 1'b0;
            CMD_PSET: n.perm = 1'b1;
            default:  n = f;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/swp_decider.sv
module swp_decider
    import swp_pkg::*;
(
    input  swp_cmd_e   cmd,
    input  swp_flags_t flags,
    input  logic       wp,
    input  logic       busy,
    output swp_plan_e  plan
);
    always_comb begin
        if (busy || flags.perm || !would_flip(cmd, flags)) begin
            plan = PLAN_REJECT;
        end else if (wp) begin
            plan = PLAN_NODATA;
        end else begin
            plan = PLAN_ALL;
        end
    end
endmodule

// File: rtl/swp_txn.sv
module swp_txn
    import swp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_any,
    input  logic       phase_vld,
    input  swp_phase_e phase,
    input  swp_cmd_e   cmd,
    input  swp_plan_e  plan_in,
    input  logic       stop,
    input  logic       busy,
    output logic       ack_vld,
    output logic       ack,
    output logic       commit,
    output swp_cmd_e   commit_cmd
);
    swp_plan_e plan_q;
    swp_cmd_e  cmd_q;
    logic      data_ok_q;
    logic      ack_d;

    always_comb begin
        ack_d = 1'b0;
        case (phase)
            PH_CMD:  ack_d = (plan_in != PLAN_REJECT);
            PH_ADDR: ack_d = (plan_q == PLAN_NODATA) || (plan_q == PLAN_ALL);
            PH_DATA: ack_d = (plan_q == PLAN_ALL);
            default: ack_d = 1'b0;
        endcase
    end

    assign commit     = stop && data_ok_q && !busy;
    assign commit_cmd = cmd_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            plan_q    <= PLAN_IDLE;
            cmd_q     <= CMD_NONE;
            data_ok_q <= 1'b0;
            ack_vld   <= 1'b0;
            ack       <= 1'b0;
        end else begin
            ack_vld <= phase_vld;
            ack     <= phase_vld && ack_d;
            if (stop) begin
                plan_q    <= PLAN_IDLE;
                data_ok_q <= 1'b0;
            end else if (phase_vld) begin
                if (phase == PH_CMD) begin
                    plan_q    <= plan_in;
                    cmd_q     <= cmd;
                    data_ok_q <= 1'b0;
                end else if (phase == PH_DATA && ack_d) begin
                    data_ok_q <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/swp_wr_timer.sv
module swp_wr_timer #(
    parameter int WR_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_any,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CNT_W = (WR_CYCLES > 2) ? $clog2(WR_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(WR_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    assign done = busy && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst_any) begin
            busy  <= 1'b0;
            cnt_q <= '0;
        end else if (busy) begin
            if (cnt_q == '0) begin
                busy <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else if (start) begin
            busy  <= 1'b1;
            cnt_q <= LOAD;
        end
    end
endmodule

// File: rtl/swp_flag_store.sv
module swp_flag_store
    import swp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_any,
    input  logic       perm_nv,
    input  logic       commit,
    input  swp_cmd_e   commit_cmd,
    input  logic       done,
    output swp_flags_t flags
);
    swp_cmd_e pend_q;

    always_ff @(posedge clk) begin
        if (rst_any) begin
            flags.rev  <= 1'b0;
            flags.perm <= perm_nv;
            pend_q     <= CMD_NONE;
        end else begin
            if (commit) begin
                pend_q <= commit_cmd;
            end
            if (done) begin
                flags <= apply_cmd(pend_q, flags);
            end
        end
    end
endmodule

// File: rtl/swp_cmd_ctrl.sv
module swp_cmd_ctrl
    import swp_pkg::*;
#(
    parameter int WR_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       por_hold,
    input  logic       perm_nv,
    input  logic       wp_pin,
    input  logic       phase_vld,
    input  logic [1:0] phase,
    input  logic [1:0] cmd,
    input  logic       stop,
    output logic       ack_vld,
    output logic       ack,
    output logic       busy,
    output logic       rev_flag,
    output logic       perm_flag,
    output logic       upper_locked,
    output logic       wr_inhibit
);
    logic       rst_any;
    swp_cmd_e   cmd_e;
    swp_phase_e phase_e;
    swp_plan_e  plan;
    swp_flags_t flags;
    logic       commit;
    swp_cmd_e   commit_cmd;
    logic       done;

    assign rst_any = rst || por_hold;
    assign cmd_e   = swp_cmd_e'(cmd);
    assign phase_e = swp_phase_e'(phase);

    swp_decider i_decider (
        .cmd   (cmd_e),
        .flags (flags),
        .wp    (wp_pin),
        .busy  (busy),
        .plan  (plan)
    );

    swp_txn i_txn (
        .clk        (clk),
        .rst_any    (rst_any),
        .phase_vld  (phase_vld),
        .phase      (phase_e),
        .cmd        (cmd_e),
        .plan_in    (plan),
        .stop       (stop),
        .busy       (busy),
        .ack_vld    (ack_vld),
        .ack        (ack),
        .commit     (commit),
        .commit_cmd (commit_cmd)
    );

    swp_wr_timer #(.WR_CYCLES(WR_CYCLES)) i_timer (
        .clk     (clk),
        .rst_any (rst_any),
        .start   (commit),
        .busy    (busy),
        .done    (done)
    );

    swp_flag_store i_flags (
        .clk        (clk),
        .rst_any    (rst_any),
        .perm_nv    (perm_nv),
        .commit     (commit),
        .commit_cmd (commit_cmd),
        .done       (done),
        .flags      (flags)
    );

    assign rev_flag     = flags.rev;
    assign perm_flag    = flags.perm;
    assign upper_locked = flags.rev || flags.perm;
    assign wr_inhibit   = por_hold;
endmodule

// File: rtl/swp_cmd_ctrl_chk.sv
module swp_cmd_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic por_hold,
    input logic phase_vld,
    input logic ack_vld,
    input logic ack,
    input logic busy,
    input logic rev_flag,
    input logic perm_flag
);
    AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (rst || por_hold)
        phase_vld |=> ack_vld); // R2
    AST_NO_SPURIOUS_ACK: assert property (@(posedge clk) disable iff (rst || por_hold)
        !phase_vld |=> !ack_vld); // R2
    AST_FLAGS_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst || por_hold)
        !busy |=> ($stable(rev_flag) && $stable(perm_flag))); // R3
    AST_PERM_LOCKOUT: assert property (@(posedge clk) disable iff (rst || por_hold)
        (perm_flag && phase_vld) |=> !ack); // R6
    AST_PERM_STICKY: assert property (@(posedge clk) disable iff (rst || por_hold)
        perm_flag |=> perm_flag); // R7
    AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (rst || por_hold)
        (busy && phase_vld) |=> !ack); // R8
endmodule

bind swp_cmd_ctrl swp_cmd_ctrl_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .por_hold  (por_hold),
    .phase_vld (phase_vld),
    .ack_vld   (ack_vld),
    .ack       (ack),
    .busy      (busy),
    .rev_flag  (rev_flag),
    .perm_flag (perm_flag)
);

// File: tb/test_swp_cmd_ctrl.sv
`timescale 1ns/1ps
module test_swp_cmd_ctrl;
    localparam int WR = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic por_hold = 1'b0;
    logic perm_nv = 1'b0;
    logic wp_pin = 1'b0;
    logic phase_vld = 1'b0;
    logic [1:0] phase = 2'd0;
    logic [1:0] cmd = 2'd0;
    logic stop = 1'b0;
    logic ack_vld, ack, busy, rev_flag, perm_flag, upper_locked, wr_inhibit;

    int tests = 0;
    int fails = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    swp_cmd_ctrl #(.WR_CYCLES(WR)) i_swp_cmd_ctrl (
        .clk(clk), .rst(rst), .por_hold(por_hold), .perm_nv(perm_nv),
        .wp_pin(wp_pin), .phase_vld(phase_vld), .phase(phase), .cmd(cmd),
        .stop(stop), .ack_vld(ack_vld), .ack(ack), .busy(busy),
        .rev_flag(rev_flag), .perm_flag(perm_flag),
        .upper_locked(upper_locked), .wr_inhibit(wr_inhibit)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0b expected %0b", req, what, act, exp);
        end
    endtask

    // Behavioural reference model, stepped on every rising edge
    bit m_live = 0;
    bit m_rev, m_perm, m_busy, m_ackv, m_ack, m_dok, m_start, m_fire, m_flip;
    int m_cnt, m_st, m_pend, m_wcmd;

    always @(posedge clk) begin
        m_live = 1;
        if (rst || por_hold) begin
            m_rev = 0; m_perm = perm_nv; m_busy = 0; m_cnt = 0;
            m_st = 0; m_dok = 0; m_ackv = 0; m_ack = 0;
        end else begin
            m_fire = m_busy && (m_cnt == 0);
            m_ackv = phase_vld;
            m_ack = 0;
            m_start = 0;
            if (stop) begin
                if (m_dok && !m_busy) begin
                    m_start = 1;
                    m_wcmd = m_pend;
                end
                m_st = 0; m_dok = 0;
            end else if (phase_vld) begin
                if (phase == 0) begin
                    m_flip = (cmd == 1 && !m_rev) || (cmd == 2 && m_rev) || (cmd == 3 && !m_perm);
                    if (m_busy || m_perm || !m_flip) m_st = 1;
                    else if (wp_pin) m_st = 2;
                    else m_st = 3;
                    m_pend = cmd; m_dok = 0;
                    m_ack = (m_st != 1);
                end else if (phase == 1) begin
                    m_ack = (m_st == 2 || m_st == 3);
                end else if (phase == 2) begin
                    m_ack = (m_st == 3);
                    if (m_ack) m_dok = 1;
                end
            end
            if (m_fire) begin
                if (m_wcmd == 1) m_rev = 1;
                else if (m_wcmd == 2) m_rev = 0;
                else if (m_wcmd == 3) m_perm = 1;
                m_busy = 0;
            end else if (m_busy) begin
                m_cnt--;
            end else if (m_start) begin
                m_busy = 1; m_cnt = WR - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (m_live) begin
            chk(cur_req, "model ack_vld", ack_vld, m_ackv);
            chk(cur_req, "model ack", ack, m_ack);
            chk(cur_req, "model busy", busy, m_busy);
            chk(cur_req, "model rev_flag", rev_flag, m_rev);
            chk(cur_req, "model perm_flag", perm_flag, m_perm);
            chk("R10", "upper_locked", upper_locked, rev_flag | perm_flag);
            chk("R1", "wr_inhibit", wr_inhibit, por_hold);
        end
    end

    task automatic byte_in(input logic [1:0] ph, input logic [1:0] c, input logic exp_ack, input string req);
        @(negedge clk);
        phase_vld = 1'b1; phase = ph; cmd = c;
        @(negedge clk);
        phase_vld = 1'b0;
        chk(req, "ack_vld", ack_vld, 1'b1);
        chk(req, "ack", ack, exp_ack);
    endtask

    task automatic send_stop();
        @(negedge clk); stop = 1'b1;
        @(negedge clk); stop = 1'b0;
    endtask

    task automatic full_cmd(input logic [1:0] c, input logic w, input logic ec, input logic ea,
                            input logic ed, input string req);
        cur_req = req;
        wp_pin = w;
        byte_in(2'd0, c, ec, req);
        byte_in(2'd1, c, ea, req);
        byte_in(2'd2, c, ed, req);
        send_stop();
    endtask

    task automatic settle();
        repeat (WR + 3) @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "ack_vld in reset", ack_vld, 1'b0);
        chk("R1", "rev in reset", rev_flag, 1'b0);
        chk("R1", "perm in reset", perm_flag, 1'b0);
        chk("R1", "busy in reset", busy, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "ack_vld after reset", ack_vld, 1'b0);

        // R3 / R8: reversible set with WP low, exact update timing
        full_cmd(2'd1, 1'b0, 1'b1, 1'b1, 1'b1, "R3");
        cur_req = "R8";
        byte_in(2'd0, 2'd2, 1'b0, "R8");
        chk("R8", "busy during write", busy, 1'b1);
        repeat (5) @(negedge clk);
        chk("R3", "rev one cycle before update", rev_flag, 1'b0);
        chk("R8", "busy one cycle before update", busy, 1'b1);
        @(negedge clk);
        chk("R3", "rev at update", rev_flag, 1'b1);
        chk("R8", "busy at update", busy, 1'b0);
        chk("R10", "upper_locked after set", upper_locked, 1'b1);
        send_stop();

        // R5: reaffirm with WP low
        full_cmd(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R5");
        @(negedge clk);
        chk("R5", "no write after reaffirm", busy, 1'b0);

        // R4: flip with WP high, data rejected
        full_cmd(2'd2, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
        settle();
        chk("R4", "rev unchanged", rev_flag, 1'b1);

        // R3: clear with WP low
        full_cmd(2'd2, 1'b0, 1'b1, 1'b1, 1'b1, "R3");
        settle();
        chk("R3", "rev cleared", rev_flag, 1'b0);
        chk("R10", "upper_locked after clear", upper_locked, 1'b0);

        // R5: reaffirm clear with WP high; code 0
        full_cmd(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R5");
        full_cmd(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, "R5");

        // R4: set with WP high
        full_cmd(2'd1, 1'b1, 1'b1, 1'b1, 1'b0, "R4");
        settle();
        chk("R4", "rev still clear", rev_flag, 1'b0);

        // R9: stop before data byte
        cur_req = "R9";
        wp_pin = 1'b0;
        byte_in(2'd0, 2'd1, 1'b1, "R9");
        byte_in(2'd1, 2'd1, 1'b1, "R9");
        send_stop();
        chk("R9", "no busy after short command", busy, 1'b0);
        settle();
        chk("R9", "rev unchanged", rev_flag, 1'b0);

        // R7: permanent set
        full_cmd(2'd3, 1'b0, 1'b1, 1'b1, 1'b1, "R7");
        settle();
        chk("R7", "perm set", perm_flag, 1'b1);
        chk("R10", "upper_locked by perm", upper_locked, 1'b1);

        // R6: everything rejected once permanent
        full_cmd(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        full_cmd(2'd2, 1'b1, 1'b0, 1'b0, 1'b0, "R6");
        full_cmd(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, "R6");
        settle();
        chk("R7", "perm never clears", perm_flag, 1'b1);

        // R1: power-on hold reloads stored value
        cur_req = "R1";
        perm_nv = 1'b1;
        @(negedge clk); por_hold = 1'b1;
        @(negedge clk);
        chk("R1", "wr_inhibit during hold", wr_inhibit, 1'b1);
        chk("R1", "rev during hold", rev_flag, 1'b0);
        chk("R1", "perm from stored value", perm_flag, 1'b1);
        @(negedge clk); por_hold = 1'b0;
        @(negedge clk);
        chk("R1", "wr_inhibit released", wr_inhibit, 1'b0);
        full_cmd(2'd1, 1'b0, 1'b0, 1'b0, 1'b0, "R6");

        // R1: reset with stored value clear
        perm_nv = 1'b0;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        chk("R1", "perm from stored clear", perm_flag, 1'b0);
        full_cmd(2'd1, 1'b0, 1'b1, 1'b1, 1'b1, "R3");
        settle();
        chk("R3", "rev set after reset", rev_flag, 1'b1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule